// File: doc/BRIEF.md
# Unconditional Call and Jump Sequencer

This block carries out the five unconditional control transfers of a 16-bit segmented processor. It handles the far call, the near relative call, the near relative jump, the far jump and the short jump. Once the opcode byte is in hand, the surrounding core pulses a start strobe and presents the opcode, the current code segment and the instruction pointer that points just past the opcode. The sequencer then pulls the operand bytes one at a time over a request/acknowledge fetch port. It assembles them least significant byte first and advances a working instruction pointer on every byte.

When the operands are in, the block computes the destination. Far forms take a segment and an offset directly from the operand. Relative forms add a sign-extended displacement to the pointer that follows the last operand byte. Calls then hand 16-bit words to the stack through a second request/acknowledge port. A far call sends the old segment and then the return pointer. A near call sends only the return pointer. Jumps send nothing.

A one-cycle done strobe marks the moment the new segment and pointer outputs are valid. An opcode outside the set is rejected with a one-cycle error strobe, and no bus activity takes place.

Top module: `xfer_seq`

## Requirements
- R1: After a synchronous reset, `fetch_req_o`, `push_req_o`, `done_o`, `err_o` and `busy_o` are all 0.
- R2: Opcodes 0x9A and 0xEA fetch four operand bytes. The first two form the new pointer (low byte first) and the last two form the new segment (low byte first).
- R3: Opcode 0x9A issues exactly two pushes: first the segment presented at start, then the return pointer, which is the start pointer plus 4 (mod 65536).
- R4: Opcode 0xEA issues no push.
- R5: Opcodes 0xE8 and 0xE9 fetch two bytes forming a signed 16-bit displacement (low byte first). The new pointer is start pointer + 2 + displacement (mod 65536), and the new segment equals the segment presented at start.
- R6: Opcode 0xE8 issues exactly one push, carrying start pointer + 2. Opcode 0xE9 issues none.
- R7: Opcode 0xEB fetches one byte, sign-extends it to 16 bits, and the new pointer is start pointer + 1 + that value (mod 65536). The segment is unchanged and nothing is pushed.
- R8: Once `push_req_o` rises it stays high, with `push_data_o` unchanged, until the cycle in which `push_ack_i` is seen. Two pushes are never served by one acknowledge.
- R9: `done_o` is high for exactly one cycle, after the last push acknowledge (or the last byte for jumps). `new_cs_o` and `new_ip_o` hold the destination while it is high.
- R10: A start with any other opcode raises `err_o` for one cycle in the next cycle. It produces no fetch request, no push request and no done.
- R11: A start strobe that arrives while the block is busy is ignored and raises no error.
- R12: `fetch_req_o` stays high until acknowledged, and exactly one operand byte is consumed per acknowledge. The working pointer wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer; sampled only when idle |
| opcode_i | input | 8 | Opcode of the transfer |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Pointer just past the opcode byte |
| fetch_req_o | output | 1 | Operand byte wanted |
| fetch_ack_i | input | 1 | Operand byte present on `fetch_data_i` |
| fetch_data_i | input | 8 | Operand byte |
| push_req_o | output | 1 | Stack word pending |
| push_ack_i | input | 1 | Stack word accepted |
| push_data_o | output | 16 | Word to push |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | One-cycle unknown-opcode strobe |
| busy_o | output | 1 | A transfer is in progress |
| new_cs_o | output | 16 | Destination segment |
| new_ip_o | output | 16 | Destination pointer |

## Verification
The bench targets the points where a transfer could be built from the wrong pieces. If the far operand halves were swapped, segment and pointer would trade places. If the return pointer were taken before the last byte, a call would return into its own operand. If the short displacement were zero-extended, a backward branch would land 256 bytes too far. If the wrap at 0xFFFF were mishandled, the return pointer would be wrong for an instruction that straddles the segment end. Back-pressure on both ports checks that a slow acknowledge neither drops nor doubles a byte or a push. Stray strobes check that a busy block does not restart, and that rejected opcodes leave both ports silent.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    XK_NONE,
    XK_CALL_FAR,
    XK_CALL_NEAR,
    XK_JMP_NEAR,
    XK_JMP_FAR,
    XK_JMP_SHORT
  } xfer_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CALC,
    ST_PUSH_SEG,
    ST_PUSH_RET,
    ST_FIN
  } seq_state_e;

  localparam logic [7:0] OPC_CALL_FAR  = 8'h9A;
  localparam logic [7:0] OPC_CALL_NEAR = 8'hE8;
  localparam logic [7:0] OPC_JMP_NEAR  = 8'hE9;
  localparam logic [7:0] OPC_JMP_FAR   = 8'hEA;
  localparam logic [7:0] OPC_JMP_SHORT = 8'hEB;

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic [BYTE_W-1:0] opcode,
  output xfer_kind_e        kind,
  output logic [CNT_W-1:0]  nbytes,
  output logic              known
);

  always_comb begin
    kind   = XK_NONE;
    nbytes = '0;
    unique case (opcode)
      BYTE_W'(OPC_CALL_FAR):  begin kind = XK_CALL_FAR;  nbytes = CNT_W'(4); end
      BYTE_W'(OPC_JMP_FAR):   begin kind = XK_JMP_FAR;   nbytes = CNT_W'(4); end
      BYTE_W'(OPC_CALL_NEAR): begin kind = XK_CALL_NEAR; nbytes = CNT_W'(2); end
      BYTE_W'(OPC_JMP_NEAR):  begin kind = XK_JMP_NEAR;  nbytes = CNT_W'(2); end
      BYTE_W'(OPC_JMP_SHORT): begin kind = XK_JMP_SHORT; nbytes = CNT_W'(1); end
      default: ;
    endcase
    known = (kind != XK_NONE);
  end

endmodule

// File: rtl/xfer_operand.sv
module xfer_operand #(
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 16,
  parameter int MAX_OPB = 4,
  parameter int CNT_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [WORD_W-1:0]           ip_init,
  input  logic                        take,
  input  logic [BYTE_W-1:0]           data_in,
  output logic [MAX_OPB*BYTE_W-1:0]   opbytes,
  output logic [WORD_W-1:0]           wip,
  output logic [CNT_W-1:0]            cnt
);

  // one capture register per operand byte slot, filled in arrival order
  for (genvar g = 0; g < MAX_OPB; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || load) begin
        opbytes[g*BYTE_W +: BYTE_W] <= '0;
      end else if (take && (cnt == CNT_W'(g))) begin
        opbytes[g*BYTE_W +: BYTE_W] <= data_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wip <= '0;
      cnt <= '0;
    end else if (load) begin
      wip <= ip_init;
      cnt <= '0;
    end else if (take) begin
      wip <= wip + WORD_W'(1);
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/xfer_target.sv
module xfer_target
  import xfer_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 16,
  parameter int MAX_OPB = 4
) (
  input  xfer_kind_e                  kind,
  input  logic [MAX_OPB*BYTE_W-1:0]   opbytes,
  input  logic [WORD_W-1:0]           wip,
  input  logic [WORD_W-1:0]           cur_cs,
  output logic [WORD_W-1:0]           tgt_cs,
  output logic [WORD_W-1:0]           tgt_ip
);

  localparam int EXT_W = WORD_W - BYTE_W;

  logic [WORD_W-1:0] word_lo;
  logic [WORD_W-1:0] word_hi;
  logic [WORD_W-1:0] short_disp;

  assign word_lo    = opbytes[WORD_W-1:0];
  assign word_hi    = opbytes[2*WORD_W-1:WORD_W];
  assign short_disp = {{EXT_W{opbytes[BYTE_W-1]}}, opbytes[BYTE_W-1:0]};

  always_comb begin
    tgt_cs = cur_cs;
    tgt_ip = wip;
    unique case (kind)
      XK_CALL_FAR, XK_JMP_FAR: begin
        tgt_cs = word_hi;
        tgt_ip = word_lo;
      end
      XK_CALL_NEAR, XK_JMP_NEAR: tgt_ip = wip + word_lo;
      XK_JMP_SHORT:              tgt_ip = wip + short_disp;
      default: ;
    endcase
  end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 16,
  parameter int MAX_OPB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] opcode_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  output logic              fetch_req_o,
  input  logic              fetch_ack_i,
  input  logic [BYTE_W-1:0] fetch_data_i,
  output logic              push_req_o,
  input  logic              push_ack_i,
  output logic [WORD_W-1:0] push_data_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] new_cs_o,
  output logic [WORD_W-1:0] new_ip_o
);

  localparam int CNT_W = $clog2(MAX_OPB + 1);

  seq_state_e                state;
  xfer_kind_e                kind_q;
  logic [CNT_W-1:0]          nbytes_q;
  logic [WORD_W-1:0]         cs_q;

  xfer_kind_e                dec_kind;
  logic [CNT_W-1:0]          dec_nbytes;
  logic                      dec_known;

  logic                      load;
  logic                      take;
  logic                      last_byte;
  logic [MAX_OPB*BYTE_W-1:0] opbytes;
  logic [WORD_W-1:0]         wip;
  logic [CNT_W-1:0]          cnt;
  logic [WORD_W-1:0]         tgt_cs;
  logic [WORD_W-1:0]         tgt_ip;

  xfer_decode #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dec (
    .opcode (opcode_i),
    .kind   (dec_kind),
    .nbytes (dec_nbytes),
    .known  (dec_known)
  );

  assign load      = (state == ST_IDLE) && start_i && dec_known;
  assign take      = (state == ST_FETCH) && fetch_ack_i;
  assign last_byte = (cnt == nbytes_q - CNT_W'(1));

  xfer_operand #(
    .BYTE_W(BYTE_W), .WORD_W(WORD_W), .MAX_OPB(MAX_OPB), .CNT_W(CNT_W)
  ) u_opnd (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .ip_init (ip_i),
    .take    (take),
    .data_in (fetch_data_i),
    .opbytes (opbytes),
    .wip     (wip),
    .cnt     (cnt)
  );

  xfer_target #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .MAX_OPB(MAX_OPB)) u_tgt (
    .kind    (kind_q),
    .opbytes (opbytes),
    .wip     (wip),
    .cur_cs  (cs_q),
    .tgt_cs  (tgt_cs),
    .tgt_ip  (tgt_ip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      kind_q      <= XK_NONE;
      nbytes_q    <= '0;
      cs_q        <= '0;
      err_o       <= 1'b0;
      new_cs_o    <= '0;
      new_ip_o    <= '0;
      push_data_o <= '0;
    end else begin
      err_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            if (dec_known) begin
              state    <= ST_FETCH;
              kind_q   <= dec_kind;
              nbytes_q <= dec_nbytes;
              cs_q     <= cs_i;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          if (fetch_ack_i && last_byte) state <= ST_CALC;
        end
        ST_CALC: begin
          new_cs_o <= tgt_cs;
          new_ip_o <= tgt_ip;
          if (kind_q == XK_CALL_FAR) begin
            push_data_o <= cs_q;
            state       <= ST_PUSH_SEG;
          end else if (kind_q == XK_CALL_NEAR) begin
            push_data_o <= wip;
            state       <= ST_PUSH_RET;
          end else begin
            state <= ST_FIN;
          end
        end
        ST_PUSH_SEG: begin
          if (push_ack_i) begin
            push_data_o <= wip;
            state       <= ST_PUSH_RET;
          end
        end
        ST_PUSH_RET: begin
          if (push_ack_i) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fetch_req_o = (state == ST_FETCH);
  assign push_req_o  = (state == ST_PUSH_SEG) || (state == ST_PUSH_RET);
  assign done_o      = (state == ST_FIN);
  assign busy_o      = (state != ST_IDLE);

endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic [7:0]  opcode_i,
  input logic        fetch_req_o,
  input logic        fetch_ack_i,
  input logic        push_req_o,
  input logic        push_ack_i,
  input logic [15:0] push_data_o,
  input logic        done_o,
  input logic        err_o,
  input logic        busy_o
);

  logic opc_ok;
  assign opc_ok = (opcode_i == 8'h9A) || (opcode_i == 8'hE8) || (opcode_i == 8'hE9) ||
                  (opcode_i == 8'hEA) || (opcode_i == 8'hEB);

  p_fetch_hold_r12: assert property (@(posedge clk) disable iff (rst)
    fetch_req_o && !fetch_ack_i |=> fetch_req_o);

  p_push_hold_r8: assert property (@(posedge clk) disable iff (rst)
    push_req_o && !push_ack_i |=> push_req_o && $stable(push_data_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !push_req_o && !fetch_req_o);

  p_ports_apart_r3: assert property (@(posedge clk) disable iff (rst)
    !(fetch_req_o && push_req_o));

  p_err_raise_r10: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o && !opc_ok |=> err_o && !busy_o && !fetch_req_o && !push_req_o);

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

  p_busy_start_r11: assert property (@(posedge clk) disable iff (rst)
    start_i && busy_o |=> !err_o);

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o && opc_ok |=> fetch_req_o);

endmodule

bind xfer_seq xfer_seq_chk i_chk (.*);

// File: tb/test_xfer_seq.sv
module test_xfer_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [15:0] cs_i = '0;
  logic [15:0] ip_i = '0;
  logic        fetch_ack_i = 1'b0;
  logic [7:0]  fetch_data_i = '0;
  logic        push_ack_i = 1'b0;
  logic        fetch_req_o, push_req_o, done_o, err_o, busy_o;
  logic [15:0] push_data_o, new_cs_o, new_ip_o;

  always #2 clk = ~clk;  // 250 MHz

  xfer_seq i_xfer_seq (.*);

  int checks = 0;
  int errors = 0;
  bit running = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- stimulus drivers for both ports ----------------
  int src[$];
  logic [15:0] obs[$];
  int fetch_gap = 0, push_gap = 0, fcnt = 0, pcnt = 0;

  always @(negedge clk) begin
    if (fetch_ack_i) fetch_ack_i = 1'b0;
    else if (fetch_req_o) begin
      if (fcnt >= fetch_gap && src.size() > 0) begin
        fetch_ack_i = 1'b1; fetch_data_i = 8'(src.pop_front()); fcnt = 0;
      end else fcnt++;
    end
    if (push_ack_i) push_ack_i = 1'b0;
    else if (push_req_o) begin
      if (pcnt >= push_gap) begin
        push_ack_i = 1'b1; obs.push_back(push_data_o); pcnt = 0;
      end else pcnt++;
    end
  end

  // ---------------- behavioural reference model ----------------
  int ph = 0, need = 0, wip_m = 0, cs_m = 0, opc_m = 0, disp = 0;
  int mb[$];
  int mq[$];
  int e_cs = 0, e_ip = 0;
  bit e_err = 0;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; e_err = 0; mq.delete();
    end else begin
      e_err = 0;
      case (ph)
        0: if (start_i) begin
          case (opcode_i)
            8'h9A, 8'hEA: need = 4;
            8'hE8, 8'hE9: need = 2;
            8'hEB:        need = 1;
            default:      need = 0;
          endcase
          if (need == 0) e_err = 1;
          else begin
            ph = 1; opc_m = opcode_i; wip_m = ip_i; cs_m = cs_i; mb.delete();
          end
        end
        1: if (fetch_ack_i) begin
          mb.push_back(fetch_data_i);
          wip_m = (wip_m + 1) % 65536;
          if (mb.size() == need) ph = 2;
        end
        2: begin
          if (need == 4) begin
            e_ip = mb[0] + 256 * mb[1];
            e_cs = mb[2] + 256 * mb[3];
          end else begin
            if (need == 2) begin
              disp = mb[0] + 256 * mb[1];
              if (disp >= 32768) disp -= 65536;
            end else begin
              disp = mb[0];
              if (disp >= 128) disp -= 256;
            end
            e_ip = (wip_m + disp + 65536) % 65536;
            e_cs = cs_m;
          end
          if (opc_m == 'h9A) begin mq.push_back(cs_m); mq.push_back(wip_m); end
          else if (opc_m == 'hE8) mq.push_back(wip_m);
          ph = (mq.size() > 0) ? 3 : 4;
        end
        3: if (push_ack_i) begin
          void'(mq.pop_front());
          if (mq.size() == 0) ph = 4;
        end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R12 fetch_req_o", 32'(fetch_req_o), 32'(ph == 1));
      chk("R8 push_req_o", 32'(push_req_o), 32'(ph == 3));
      if (ph == 3 && mq.size() > 0) chk("R3 push_data_o", 32'(push_data_o), 32'(mq[0]));
      chk("R9 done_o", 32'(done_o), 32'(ph == 4));
      chk("R10 err_o", 32'(err_o), 32'(e_err));
      chk("R11 busy_o", 32'(busy_o), 32'(ph != 0));
      if (ph == 4) begin
        chk("R2 new_cs_o model", 32'(new_cs_o), 32'(e_cs));
        chk("R5 new_ip_o model", 32'(new_ip_o), 32'(e_ip));
      end
    end
  end

  // ---------------- scenario tasks ----------------
  task automatic run_op(input string tag, input logic [7:0] op, input logic [15:0] cs,
                        input logic [15:0] ip, input int nb, input logic [7:0] b0,
                        input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                        input logic [15:0] xcs, input logic [15:0] xip, input int np,
                        input logic [15:0] p0, input logic [15:0] p1,
                        input int fg, input int pg, input bit stray);
    src.delete(); obs.delete();
    if (nb > 0) src.push_back(b0);
    if (nb > 1) src.push_back(b1);
    if (nb > 2) src.push_back(b2);
    if (nb > 3) src.push_back(b3);
    fetch_gap = fg; push_gap = pg;
    @(negedge clk);
    start_i = 1'b1; opcode_i = op; cs_i = cs; ip_i = ip;
    @(negedge clk);
    start_i = 1'b0;
    if (stray) begin
      start_i = 1'b1; opcode_i = 8'h90;
      @(negedge clk);
      start_i = 1'b0;
      chk({tag, " R11 stray start gives no err"}, 32'(err_o), 32'd0);
    end
    while (!done_o) @(negedge clk);
    chk({tag, " R2 new_cs_o"}, 32'(new_cs_o), 32'(xcs));
    chk({tag, " R5 new_ip_o"}, 32'(new_ip_o), 32'(xip));
    chk({tag, " R6 push count"}, 32'(obs.size()), 32'(np));
    if (np > 0 && obs.size() > 0) chk({tag, " R3 first push"}, 32'(obs[0]), 32'(p0));
    if (np > 1 && obs.size() > 1) chk({tag, " R3 second push"}, 32'(obs[1]), 32'(p1));
    chk({tag, " R12 all bytes used"}, 32'(src.size()), 32'd0);
    @(negedge clk);
  endtask

  task automatic bad_op(input logic [7:0] op);
    @(negedge clk);
    start_i = 1'b1; opcode_i = op;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 err_o raised", 32'(err_o), 32'd1);
    chk("R10 no fetch", 32'(fetch_req_o), 32'd0);
    @(negedge clk);
    chk("R10 err_o single cycle", 32'(err_o), 32'd0);
    chk("R10 no push, no done", 32'({push_req_o, done_o, busy_o}), 32'd0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset outputs", 32'({fetch_req_o, push_req_o, done_o, err_o, busy_o}), 32'd0);
    running = 1;
    // R4 far jump: operand order offset lo/hi then segment lo/hi
    run_op("farjmp", 8'hEA, 16'h1000, 16'h1000, 4, 8'h34, 8'h12, 8'h00, 8'hF0,
           16'hF000, 16'h1234, 0, 16'h0, 16'h0, 0, 0, 0);
    // R3 far call with slow stack
    run_op("farcall", 8'h9A, 16'h2000, 16'h0100, 4, 8'h78, 8'h56, 8'hCD, 8'hAB,
           16'hABCD, 16'h5678, 2, 16'h2000, 16'h0104, 1, 3, 0);
    // R6 near call forward
    run_op("nearcall", 8'hE8, 16'h3000, 16'h0200, 2, 8'h10, 8'h00, 8'h0, 8'h0,
           16'h3000, 16'h0212, 1, 16'h0202, 16'h0, 0, 2, 0);
    // R5 near jump backward
    run_op("nearjmp", 8'hE9, 16'h4000, 16'h0300, 2, 8'h00, 8'hFF, 8'h0, 8'h0,
           16'h4000, 16'h0202, 0, 16'h0, 16'h0, 2, 0, 0);
    // R7 short jump, largest forward
    run_op("short+", 8'hEB, 16'h5000, 16'h0400, 1, 8'h7F, 8'h0, 8'h0, 8'h0,
           16'h5000, 16'h0480, 0, 16'h0, 16'h0, 0, 0, 0);
    // R7 short jump, largest backward, wraps below zero
    run_op("short-", 8'hEB, 16'h5000, 16'h0010, 1, 8'h80, 8'h0, 8'h0, 8'h0,
           16'h5000, 16'hFF91, 0, 16'h0, 16'h0, 1, 0, 0);
    // R12 pointer wraps while fetching a near call
    run_op("wrap", 8'hE8, 16'h6000, 16'hFFFF, 2, 8'h05, 8'h00, 8'h0, 8'h0,
           16'h6000, 16'h0006, 1, 16'h0001, 16'h0, 0, 0, 0);
    // R11 stray start during a far call
    run_op("stray", 8'h9A, 16'h7000, 16'h0800, 4, 8'h11, 8'h22, 8'h33, 8'h44,
           16'h4433, 16'h2211, 2, 16'h7000, 16'h0804, 2, 1, 1);
    // R10 rejected opcodes
    bad_op(8'h90);
    bad_op(8'h70);
    // R4 far jump back to back after an error
    run_op("farjmp2", 8'hEA, 16'h0000, 16'hFFFE, 4, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
           16'hFFFF, 16'hFFFF, 0, 16'h0, 16'h0, 0, 0, 0);
    running = 0;
    finish_run();
  end

endmodule